// File: doc/BRIEF.md
# Branch and Trap Condition Evaluator

This purely combinational block looks at the decoded fields of one instruction (major opcode, function code and the rt selector) together with two register operands and a short immediate. It answers a single question: does this conditional branch go, or does this conditional trap fire? Next to that answer it reports two static properties of the encoding. One says the instruction writes a return link. The other says it is a "likely" form, so the delay slot must be squashed when the branch does not go. A fifth output marks any encoding that the block does not recognise.

The comparisons come from one shared compare path that produces equal, signed-less-than and unsigned-less-than. The second operand is picked per encoding from the rt operand, the sign-extended immediate, or zero. Target address generation and the handling of a raised trap are left to neighbouring logic. Operand width and immediate width are parameters (`DATA_W`, `IMM_W`). The immediate is always sign-extended to `DATA_W`.

Top module: `brtrap_eval`

## Requirements
- R1: With major opcode 0x00, function codes 0x30, 0x31, 0x32, 0x33, 0x34 and 0x36 raise `trap_o` when rs>=rt signed, rs>=rt unsigned, rs<rt signed, rs<rt unsigned, rs==rt and rs!=rt respectively. `taken_o`, `link_o` and `likely_o` stay low.
- R2: With major opcode 0x01, rt selector values 0x08, 0x09, 0x0A, 0x0B, 0x0C and 0x0E apply the R1 predicates in that order, with rs against the sign-extended immediate. The unsigned forms read the sign-extended immediate as an unsigned `DATA_W`-bit value.
- R3: With major opcode 0x01, rt selector 0x00 is taken when rs<0 and 0x01 when rs>=0, both signed. Selectors 0x02 and 0x03 test the same conditions as likely forms.
- R4: With major opcode 0x01, rt selectors 0x10/0x11 are the linking forms of the rs<0 / rs>=0 tests, and 0x12/0x13 are their linking likely forms.
- R5: Major opcodes 0x04, 0x05, 0x06 and 0x07 are taken on rs==rt, rs!=rt, rs<=0 signed and rs>0 signed. Opcodes 0x14 to 0x17 test the same four conditions as likely forms.
- R6: `link_o` is high for every linking form, whether or not the branch is taken, and low for every other encoding.
- R7: `likely_o` is high for every likely form, whether or not the branch is taken, and low for every other encoding.
- R8: Any encoding not listed in R1 to R5 drives `rsvd_o` high and holds `taken_o`, `trap_o`, `link_o` and `likely_o` low.
- R9: `taken_o` is only ever high for branch encodings and `trap_o` only for trap encodings. At most one of `taken_o`, `trap_o` and `rsvd_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Major opcode field |
| funct_i | input | 6 | Function field, used under opcode 0x00 |
| rt_sel_i | input | 5 | rt field, used as a sub-opcode under opcode 0x01 |
| rs_val_i | input | DATA_W | First register operand |
| rt_val_i | input | DATA_W | Second register operand |
| imm_i | input | IMM_W | Immediate, sign-extended inside the block |
| taken_o | output | 1 | Branch condition holds |
| trap_o | output | 1 | Trap condition holds |
| link_o | output | 1 | Encoding is a linking branch |
| likely_o | output | 1 | Encoding is a likely branch |
| rsvd_o | output | 1 | Encoding not recognised |

## Verification
The bench builds the block with `DATA_W` = 8 and `IMM_W` = 4. At those widths every pair of register operands can be tried for all six register-register trap codes. Every operand is tried against all sixteen immediates for the immediate traps. Each compare-to-zero and equality branch sees every rs value. The narrow widths bring the sign-boundary cases (0x7F against 0x80, and a negative immediate read as a large unsigned value) into every sweep. Opcode, function and rt-selector spaces are swept in full to check the reserved flag.

// File: rtl/brtrap_eval.sv
module brtrap_eval #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [5:0]        op_i,
  input  logic [5:0]        funct_i,
  input  logic [4:0]        rt_sel_i,
  input  logic [DATA_W-1:0] rs_val_i,
  input  logic [DATA_W-1:0] rt_val_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic              taken_o,
  output logic              trap_o,
  output logic              link_o,
  output logic              likely_o,
  output logic              rsvd_o
);

  typedef enum logic [1:0] {SRC_RT, SRC_IMM, SRC_ZERO} src_e;
  typedef enum logic [2:0] {P_GES, P_GEU, P_LTS, P_LTU, P_EQ, P_NE, P_LEZ, P_GTZ} pred_e;

  logic [DATA_W-1:0] imm_x, opb;
  logic              is_br, is_tr;
  src_e              src;
  pred_e             pred;
  logic              eq, lts, ltu, cond;

  generate
    if (DATA_W > IMM_W) begin : g_sext
      assign imm_x = {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
    end else begin : g_trunc
      assign imm_x = imm_i[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    is_br    = 1'b0;
    is_tr    = 1'b0;
    link_o   = 1'b0;
    likely_o = 1'b0;
    src      = SRC_ZERO;
    pred     = P_EQ;
    unique case (op_i)
      6'h00: begin
        src = SRC_RT;
        is_tr = 1'b1;
        case (funct_i)
          6'h30: pred = P_GES;
          6'h31: pred = P_GEU;
          6'h32: pred = P_LTS;
          6'h33: pred = P_LTU;
          6'h34: pred = P_EQ;
          6'h36: pred = P_NE;
          default: is_tr = 1'b0;
        endcase
      end
      6'h01: begin
        case (rt_sel_i)
          5'h08, 5'h09, 5'h0A, 5'h0B, 5'h0C, 5'h0E: begin
            is_tr = 1'b1;
            src   = SRC_IMM;
            case (rt_sel_i[2:0])
              3'd0: pred = P_GES;
              3'd1: pred = P_GEU;
              3'd2: pred = P_LTS;
              3'd3: pred = P_LTU;
              3'd4: pred = P_EQ;
              default: pred = P_NE;
            endcase
          end
          5'h00, 5'h01, 5'h02, 5'h03, 5'h10, 5'h11, 5'h12, 5'h13: begin
            is_br    = 1'b1;
            pred     = rt_sel_i[0] ? P_GES : P_LTS;
            link_o   = rt_sel_i[4];
            likely_o = rt_sel_i[1];
          end
          default: ;
        endcase
      end
      6'h04, 6'h05, 6'h06, 6'h07, 6'h14, 6'h15, 6'h16, 6'h17: begin
        is_br    = 1'b1;
        likely_o = op_i[4];
        case (op_i[1:0])
          2'd0: begin pred = P_EQ;  src = SRC_RT; end
          2'd1: begin pred = P_NE;  src = SRC_RT; end
          2'd2: pred = P_LEZ;
          default: pred = P_GTZ;
        endcase
      end
      default: ;
    endcase
  end

  always_comb begin
    case (src)
      SRC_RT:  opb = rt_val_i;
      SRC_IMM: opb = imm_x;
      default: opb = '0;
    endcase
  end

  assign eq  = (rs_val_i == opb);
  assign ltu = (rs_val_i < opb);
  assign lts = ($signed(rs_val_i) < $signed(opb));

  always_comb begin
    case (pred)
      P_GES:   cond = ~lts;
      P_GEU:   cond = ~ltu;
      P_LTS:   cond = lts;
      P_LTU:   cond = ltu;
      P_EQ:    cond = eq;
      P_NE:    cond = ~eq;
      P_LEZ:   cond = lts | eq;
      default: cond = ~(lts | eq);
    endcase
  end

  assign taken_o = is_br & cond;
  assign trap_o  = is_tr & cond;
  assign rsvd_o  = ~(is_br | is_tr);

  always_comb begin
    if (!$isunknown({op_i, funct_i, rt_sel_i, rs_val_i, rt_val_i, imm_i})) begin
      // R9
      excl_flags_chk: assert ($onehot0({taken_o, trap_o, rsvd_o}));
      // R8
      rsvd_quiet_chk: assert (!rsvd_o || !(link_o || likely_o));
      // R6
      link_space_chk: assert (!link_o || (op_i == 6'h01 && rt_sel_i[4]));
      // R9
      trap_space_chk: assert (!trap_o || op_i == 6'h00 || op_i == 6'h01);
      // R5
      beq_self_chk: assert (!(op_i == 6'h04 && rs_val_i == rt_val_i) || taken_o);
      // R7
      likely_notrap_chk: assert (!likely_o || !trap_o);
    end
  end

endmodule

// File: tb/brtrap_eval_bench.sv
module brtrap_eval_bench;
  localparam int DW = 8;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [5:0]    op;
  logic [5:0]    fn;
  logic [4:0]    rs_sel;
  logic [DW-1:0] a, b;
  logic [IW-1:0] imm;
  logic taken, trap, link, likely, rsvd;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  brtrap_eval #(.DATA_W(DW), .IMM_W(IW)) u_brtrap_eval (
    .op_i(op), .funct_i(fn), .rt_sel_i(rs_sel), .rs_val_i(a), .rt_val_i(b),
    .imm_i(imm), .taken_o(taken), .trap_o(trap), .link_o(link),
    .likely_o(likely), .rsvd_o(rsvd)
  );

  // expected {taken, trap, link, likely, rsvd}
  function automatic logic [4:0] model(input logic [5:0] o, input logic [5:0] f,
                                       input logic [4:0] r, input int av, input int bv,
                                       input int iv);
    int sa, sb, si, ui;
    logic c;
    sa = (av >= 128) ? av - 256 : av;
    sb = (bv >= 128) ? bv - 256 : bv;
    si = (iv >= 8) ? iv - 16 : iv;
    ui = (si < 0) ? si + 256 : si;
    model = 5'b00001;
    if (o == 6'h00) begin
      case (f)
        6'h30: model = {1'b0, sa >= sb, 3'b000};
        6'h31: model = {1'b0, av >= bv, 3'b000};
        6'h32: model = {1'b0, sa < sb, 3'b000};
        6'h33: model = {1'b0, av < bv, 3'b000};
        6'h34: model = {1'b0, av == bv, 3'b000};
        6'h36: model = {1'b0, av != bv, 3'b000};
        default: ;
      endcase
    end else if (o == 6'h01) begin
      case (r)
        5'h08: model = {1'b0, sa >= si, 3'b000};
        5'h09: model = {1'b0, av >= ui, 3'b000};
        5'h0A: model = {1'b0, sa < si, 3'b000};
        5'h0B: model = {1'b0, av < ui, 3'b000};
        5'h0C: model = {1'b0, av == ui, 3'b000};
        5'h0E: model = {1'b0, av != ui, 3'b000};
        5'h00, 5'h01, 5'h02, 5'h03, 5'h10, 5'h11, 5'h12, 5'h13: begin
          c = r[0] ? (sa >= 0) : (sa < 0);
          model = {c, 1'b0, r[4], r[1], 1'b0};
        end
        default: ;
      endcase
    end else if (o inside {6'h04, 6'h05, 6'h06, 6'h07, 6'h14, 6'h15, 6'h16, 6'h17}) begin
      case (o[1:0])
        2'd0: c = (av == bv);
        2'd1: c = (av != bv);
        2'd2: c = (sa <= 0);
        default: c = (sa > 0);
      endcase
      model = {c, 2'b00, o[4] == 1'b1, 1'b0};
    end
  endfunction

  task automatic apply(input logic [5:0] o, input logic [5:0] f, input logic [4:0] r,
                       input int av, input int bv, input int iv, input string req);
    logic [4:0] exp;
    op = o; fn = f; rs_sel = r; a = av[DW-1:0]; b = bv[DW-1:0]; imm = iv[IW-1:0];
    #1;
    exp = model(o, f, r, av, bv, iv);
    n_vec++;
    if ({taken, trap, link, likely, rsvd} !== exp) begin
      n_bad++;
      $display("FAIL %s op=%h fn=%h rt=%h a=%h b=%h imm=%h got=%b exp=%b",
               req, o, f, r, av[7:0], bv[7:0], iv[3:0], {taken, trap, link, likely, rsvd}, exp);
    end
    #1;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 180000 && !done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    op = '0; fn = '0; rs_sel = '0; a = '0; b = '0; imm = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: all-zero encoding is not recognised
    apply(6'h00, 6'h00, 5'h00, 0, 0, 0, "R8");
    // R1: register-register traps, full operand sweep
    foreach (fn_l[k]) ;
    for (int k = 0; k < 6; k++) begin
      logic [5:0] fc;
      fc = (k == 5) ? 6'h36 : 6'(6'h30 + k);
      for (int x = 0; x < 256; x++)
        for (int y = 0; y < 256; y++)
          apply(6'h00, fc, 5'h00, x, y, 0, "R1");
    end
    // R2: register-immediate traps against every immediate
    for (int k = 0; k < 6; k++) begin
      logic [4:0] rc;
      rc = (k == 5) ? 5'h0E : 5'(5'h08 + k);
      for (int x = 0; x < 256; x++)
        for (int i = 0; i < 16; i++)
          apply(6'h01, 6'h00, rc, x, 0, i, "R2");
    end
    // R3 R4 R6 R7: compare-to-zero branches, plain/likely/link
    for (int k = 0; k < 8; k++) begin
      logic [4:0] rc;
      rc = {k[2], 2'b00, k[1:0]};
      for (int x = 0; x < 256; x++)
        apply(6'h01, 6'h00, rc, x, x ^ 8'h5A, 0, k[2] ? "R4_R6" : "R3_R7");
    end
    // R5 R7: major-opcode branches
    for (int k = 0; k < 8; k++) begin
      logic [5:0] oc;
      oc = {1'b0, k[2], 2'b01, k[1:0]};
      for (int x = 0; x < 256; x++)
        for (int j = 0; j < 16; j++)
          apply(oc, 6'h00, 5'h00, x, (j == 0) ? x : ((x + j * 37) & 255), 0, "R5_R7");
    end
    // R8 R9: encoding-space sweeps
    for (int f = 0; f < 64; f++) apply(6'h00, 6'(f), 5'h1F, 3, 200, 0, "R8_R9");
    for (int r = 0; r < 32; r++) apply(6'h01, 6'h3F, 5'(r), 130, 7, 9, "R8_R9");
    for (int o = 0; o < 64; o++) apply(6'(o), 6'h30, 5'h08, 128, 128, 15, "R8_R9");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  int fn_l[1];
endmodule